// File: doc/BRIEF.md
# Parallel Flash Bus Cycle Sequencer

This block is a synchronous engine that runs bus cycles on an asynchronous, byte-wide parallel flash with a 19-bit address and an 8-bit data bus. A host issues single read or write cycles, or asks for a completion poll after it has started an embedded program or erase. The sequencer drives chip select, output enable, write enable and the enable of its own data drivers. Every strobe edge comes from a minimum interval in nanoseconds, which elaboration turns into whole clocks, rounding up.

For a poll, the block repeats status reads at the request address and watches one status bit. That bit stops changing once the embedded operation has finished. The poll ends when two consecutive reads agree, or with an error once a per-operation clock budget has run out. The short budget is for byte programs and the long one is for erases. Each request is answered by a one-clock acknowledge, which carries the read byte and the error flag.

Top module: `flash_cycle_seq`

## Requirements
- R1: While reset is high and after it is released, chip select, output enable and write enable (all active low) sit high, the data drivers are off, and acknowledge, error and busy are low.
- R2: In a read (req_op 00), chip select and output enable go low together for exactly C_ACC clocks, where C_ACC = max(1, ceil(RD_ACC_NS/CLK_NS)). rdata is the bus value sampled on the clock edge that ends that window.
- R3: After output enable rises, the bus is left undriven for C_FLT = max(1, ceil(RD_FLT_NS/CLK_NS)) clocks before acknowledge. The read acknowledge therefore comes C_ACC+C_FLT clocks after acceptance.
- R4: In a write (req_op 01), address, data and chip select are presented for C_SU clocks before write enable falls. Write enable then stays low for C_PW clocks, and all three are held for C_HD clocks after it rises, with C_HD = max(ceil(WR_HD_NS/CLK_NS), ceil(WR_CYC_NS/CLK_NS)-C_SU-C_PW). Acknowledge follows C_SU+C_PW+C_HD clocks after acceptance.
- R5: Output enable and write enable are never low together, and the data drivers are never on while output enable is low.
- R6: A request is taken only while the block is idle. A request raised during a cycle and dropped before the cycle ends has no effect.
- R7: Acknowledge is high for exactly one clock per request.
- R8: A poll (req_op 10 or 11) issues back-to-back status reads at the request address and compares bit 6 of each read with the previous read. It ends without error after the first read whose bit 6 equals that of the read before, and acknowledges after n full read cycles with rdata set to the last byte.
- R9: If a poll read ends without a match and more than the limit of clocks have passed since acceptance, the poll ends with err high alongside acknowledge. The limit is PGM_LIM_CLK for req_op 10 and ERS_LIM_CLK for req_op 11.
- R10: While chip select stays low, the flash address does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request strobe, taken when idle |
| req_op | input | 2 | 00 read, 01 write, 10 poll program, 11 poll erase |
| req_addr | input | 19 | Flash byte address |
| req_wdata | input | 8 | Byte to write |
| busy | output | 1 | A cycle or poll is in progress |
| ack | output | 1 | One-clock completion pulse |
| err | output | 1 | Poll timed out, valid with ack |
| rdata | output | 8 | Byte read, valid with ack |
| fl_addr | output | 19 | Flash address bus |
| fl_ce_n | output | 1 | Chip select, active low |
| fl_oe_n | output | 1 | Output enable, active low |
| fl_we_n | output | 1 | Write enable, active low |
| fl_dq_out | output | 8 | Data to drive onto the flash bus |
| fl_dq_oe | output | 1 | Enable for the data drivers |
| fl_dq_in | input | 8 | Data read from the flash bus |

## Verification
The assertions assume that the host keeps the request fields steady on the clock edge where req is seen in idle. They also assume the elaborated interval counts are at least one clock, which the rounding helper guarantees. The bench changes req, req_op and the data fields only on falling clock edges, and it drops req one clock after acceptance so that no cycle is accidentally repeated. Its flash model returns valid data only after output enable has been low for the full access count. Its status byte flips bit 6 after each read for a chosen number of reads, or forever when it is exercising the timeout.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACT,
    ST_RD_FLT,
    ST_WR_SU,
    ST_WR_PW,
    ST_WR_HD
  } fseq_state_e;

  typedef enum logic [1:0] {
    OP_READ     = 2'b00,
    OP_WRITE    = 2'b01,
    OP_POLL_PGM = 2'b10,
    OP_POLL_ERS = 2'b11
  } fseq_op_e;

  // round a nanosecond interval up to whole clocks, at least one
  function automatic int ns_to_clk(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fseq_interval.sv
module fseq_interval #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          last
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= load_val;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign last = (cnt == CW'(1));

  // R2
  load_zero_chk: assert property (@(posedge clk) disable iff (rst)
    load |-> (load_val != '0));

endmodule

// File: rtl/fseq_toggle_poll.sv
module fseq_toggle_poll #(
  parameter int          TW      = 32,
  parameter logic [TW-1:0] PGM_LIM = '0,
  parameter logic [TW-1:0] ERS_LIM = '0
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic use_erase,
  input  logic sample,
  input  logic stat_bit,
  output logic steady,
  output logic expired
);

  logic [TW-1:0] elapsed;
  logic [TW-1:0] limit_q;
  logic          prev_bit;
  logic          have_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      elapsed   <= '0;
      limit_q   <= '0;
      prev_bit  <= 1'b0;
      have_prev <= 1'b0;
      steady    <= 1'b0;
    end else if (start) begin
      elapsed   <= '0;
      limit_q   <= use_erase ? ERS_LIM : PGM_LIM;
      have_prev <= 1'b0;
      steady    <= 1'b0;
    end else begin
      if (elapsed != '1)
        elapsed <= elapsed + 1'b1;
      if (sample) begin
        prev_bit  <= stat_bit;
        have_prev <= 1'b1;
        steady    <= have_prev && (stat_bit == prev_bit);
      end
    end
  end

  assign expired = (elapsed >= limit_q);

  // R8
  first_read_chk: assert property (@(posedge clk) disable iff (rst)
    (sample && !have_prev && !start) |=> !steady);

endmodule

// File: rtl/flash_cycle_seq.sv
module flash_cycle_seq
  import fseq_pkg::*;
#(
  parameter int AW          = 19,
  parameter int DW          = 8,
  parameter int STAT_BIT    = 6,
  parameter int CLK_NS      = 20,
  parameter int RD_ACC_NS   = 70,
  parameter int RD_FLT_NS   = 20,
  parameter int WR_SU_NS    = 0,
  parameter int WR_PW_NS    = 35,
  parameter int WR_HD_NS    = 45,
  parameter int WR_CYC_NS   = 70,
  parameter int PGM_LIM_CLK = 5000,
  parameter int ERS_LIM_CLK = 1500000000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          busy,
  output logic          ack,
  output logic          err,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] fl_addr,
  output logic          fl_ce_n,
  output logic          fl_oe_n,
  output logic          fl_we_n,
  output logic [DW-1:0] fl_dq_out,
  output logic          fl_dq_oe,
  input  logic [DW-1:0] fl_dq_in
);

  localparam int C_ACC = ns_to_clk(RD_ACC_NS, CLK_NS);
  localparam int C_FLT = ns_to_clk(RD_FLT_NS, CLK_NS);
  localparam int C_SU  = ns_to_clk(WR_SU_NS, CLK_NS);
  localparam int C_PW  = ns_to_clk(WR_PW_NS, CLK_NS);
  localparam int C_HD  = imax(ns_to_clk(WR_HD_NS, CLK_NS),
                              ns_to_clk(WR_CYC_NS, CLK_NS) - C_SU - C_PW);
  localparam int C_MAX = imax(imax(C_ACC, C_FLT), imax(imax(C_SU, C_PW), C_HD));
  localparam int CW    = $clog2(C_MAX + 1);
  localparam int L_MAX = imax(PGM_LIM_CLK, ERS_LIM_CLK);
  localparam int TW    = $clog2(L_MAX + 1) + 1;

  localparam logic [CW-1:0] V_ACC = CW'(C_ACC);
  localparam logic [CW-1:0] V_FLT = CW'(C_FLT);
  localparam logic [CW-1:0] V_SU  = CW'(C_SU);
  localparam logic [CW-1:0] V_PW  = CW'(C_PW);
  localparam logic [CW-1:0] V_HD  = CW'(C_HD);

  fseq_state_e   state, nxt;
  fseq_op_e      op_in;
  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          tmr_last;
  logic          smp;
  logic          poll_start;
  logic          polling;
  logic          steady;
  logic          expired;

  assign op_in = fseq_op_e'(req_op);

  fseq_interval #(.CW(CW)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .last     (tmr_last)
  );

  fseq_toggle_poll #(
    .TW      (TW),
    .PGM_LIM (TW'(PGM_LIM_CLK)),
    .ERS_LIM (TW'(ERS_LIM_CLK))
  ) u_poll (
    .clk       (clk),
    .rst       (rst),
    .start     (poll_start),
    .use_erase (req_op[0]),
    .sample    (smp),
    .stat_bit  (fl_dq_in[STAT_BIT]),
    .steady    (steady),
    .expired   (expired)
  );

  // next-state and interval loading
  always_comb begin
    nxt        = state;
    tmr_load   = 1'b0;
    tmr_val    = '0;
    smp        = 1'b0;
    poll_start = 1'b0;
    case (state)
      ST_IDLE: begin
        if (req) begin
          tmr_load = 1'b1;
          case (op_in)
            OP_WRITE: begin
              nxt     = ST_WR_SU;
              tmr_val = V_SU;
            end
            OP_POLL_PGM, OP_POLL_ERS: begin
              nxt        = ST_RD_ACT;
              tmr_val    = V_ACC;
              poll_start = 1'b1;
            end
            default: begin
              nxt     = ST_RD_ACT;
              tmr_val = V_ACC;
            end
          endcase
        end
      end
      ST_RD_ACT: begin
        if (tmr_last) begin
          smp      = 1'b1;
          nxt      = ST_RD_FLT;
          tmr_load = 1'b1;
          tmr_val  = V_FLT;
        end
      end
      ST_RD_FLT: begin
        if (tmr_last) begin
          if (!polling || steady || expired) begin
            nxt = ST_IDLE;
          end else begin
            nxt      = ST_RD_ACT;
            tmr_load = 1'b1;
            tmr_val  = V_ACC;
          end
        end
      end
      ST_WR_SU: begin
        if (tmr_last) begin
          nxt      = ST_WR_PW;
          tmr_load = 1'b1;
          tmr_val  = V_PW;
        end
      end
      ST_WR_PW: begin
        if (tmr_last) begin
          nxt      = ST_WR_HD;
          tmr_load = 1'b1;
          tmr_val  = V_HD;
        end
      end
      ST_WR_HD: begin
        if (tmr_last)
          nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  // registered state and bus outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      polling   <= 1'b0;
      fl_addr   <= '0;
      fl_dq_out <= '0;
      fl_ce_n   <= 1'b1;
      fl_oe_n   <= 1'b1;
      fl_we_n   <= 1'b1;
      fl_dq_oe  <= 1'b0;
      rdata     <= '0;
      ack       <= 1'b0;
      err       <= 1'b0;
    end else begin
      state <= nxt;
      if (state == ST_IDLE && req) begin
        fl_addr   <= req_addr;
        fl_dq_out <= req_wdata;
        polling   <= req_op[1];
      end
      fl_ce_n  <= (nxt == ST_IDLE) || (nxt == ST_RD_FLT);
      fl_oe_n  <= (nxt != ST_RD_ACT);
      fl_we_n  <= (nxt != ST_WR_PW);
      fl_dq_oe <= (nxt == ST_WR_SU) || (nxt == ST_WR_PW) || (nxt == ST_WR_HD);
      if (smp)
        rdata <= fl_dq_in;
      ack <= (state != ST_IDLE) && (nxt == ST_IDLE);
      err <= (state == ST_RD_FLT) && (nxt == ST_IDLE) && polling && !steady;
    end
  end

  assign busy = (state != ST_IDLE);

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!fl_oe_n && !fl_we_n));

  // R5
  bus_turn_chk: assert property (@(posedge clk) disable iff (rst)
    fl_dq_oe |-> fl_oe_n);

  // R7
  ack_once_chk: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);

  // R6
  ack_idle_chk: assert property (@(posedge clk) disable iff (rst)
    ack |-> !busy);

  // R10
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!fl_ce_n && $past(!fl_ce_n)) |-> $stable(fl_addr));

  // R4
  we_framed_chk: assert property (@(posedge clk) disable iff (rst)
    (!fl_we_n || $rose(fl_we_n)) |-> (!fl_ce_n && fl_dq_oe));

  // R9
  err_with_ack_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> ack);

endmodule

// File: tb/sim_flash_cycle_seq.sv
module sim_flash_cycle_seq;

  localparam int CLK_PERIOD = 10;
  localparam int P_ACC_NS = 30, P_FLT_NS = 20, P_SU_NS = 0, P_PW_NS = 25;
  localparam int P_HD_NS = 15, P_CYC_NS = 70, P_PGM = 40, P_ERS = 120;

  // expected clock counts from the requirement formulas
  localparam int E_ACC = 3;
  localparam int E_FLT = 2;
  localparam int E_SU  = 1;
  localparam int E_PW  = 3;
  localparam int E_HD  = 3;
  localparam int E_RC  = E_ACC + E_FLT;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic [1:0]  req_op = 2'b00;
  logic [18:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        busy, ack, err;
  logic [7:0]  rdata;
  logic [18:0] fl_addr;
  logic        fl_ce_n, fl_oe_n, fl_we_n, fl_dq_oe;
  logic [7:0]  fl_dq_out;
  logic [7:0]  fl_dq_in;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cycle_seq #(
    .CLK_NS(CLK_PERIOD), .RD_ACC_NS(P_ACC_NS), .RD_FLT_NS(P_FLT_NS),
    .WR_SU_NS(P_SU_NS), .WR_PW_NS(P_PW_NS), .WR_HD_NS(P_HD_NS),
    .WR_CYC_NS(P_CYC_NS), .PGM_LIM_CLK(P_PGM), .ERS_LIM_CLK(P_ERS)
  ) u0 (
    .clk(clk), .rst(rst), .req(req), .req_op(req_op), .req_addr(req_addr),
    .req_wdata(req_wdata), .busy(busy), .ack(ack), .err(err), .rdata(rdata),
    .fl_addr(fl_addr), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n),
    .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- flash model and monitors ----------------
  logic [7:0] mem [64];
  int  acc_run = 0;
  int  rd_len = 0;
  int  rd_count = 0;
  int  su_cnt = 0, pw_cnt = 0, hd_cnt = 0, fall_cnt = 0;
  bit  seen_fall = 0;
  int  excl_bad = 0;
  bit  poll_mode = 0;
  bit  tog = 0;
  int  tog_left = 0;
  bit  tog_forever = 0;
  logic prev_oe = 1'b1, prev_we = 1'b1;
  logic [18:0] wr_addr_seen = '0;

  function automatic logic [7:0] stat_byte(input bit t);
    return {1'b1, t, 6'b010101};
  endfunction

  always_comb begin
    if (!fl_ce_n && !fl_oe_n && acc_run >= E_ACC)
      fl_dq_in = poll_mode ? stat_byte(tog) : mem[fl_addr[5:0]];
    else
      fl_dq_in = 8'h00;
  end

  always @(negedge clk) begin
    if (!fl_ce_n && !fl_oe_n) acc_run = acc_run + 1;
    else acc_run = 0;
    if (!fl_oe_n && !fl_we_n) excl_bad++;
    if (fl_dq_oe && !fl_oe_n) excl_bad++;
    if (!prev_oe && fl_oe_n) begin
      rd_count++;
      if (poll_mode && (tog_forever || tog_left > 0)) begin
        tog = ~tog;
        if (!tog_forever) tog_left--;
      end
    end
    if (!fl_oe_n) rd_len++;
    if (prev_we && !fl_we_n) begin
      seen_fall = 1;
      fall_cnt++;
      wr_addr_seen = fl_addr;
    end
    if (!prev_we && fl_we_n) mem[fl_addr[5:0]] = fl_dq_out;
    if (!fl_we_n) pw_cnt++;
    if (!fl_ce_n && fl_we_n && !seen_fall) su_cnt++;
    if (!fl_ce_n && fl_we_n && seen_fall) hd_cnt++;
    prev_oe = fl_oe_n;
    prev_we = fl_we_n;
  end

  task automatic clear_mon();
    rd_len = 0; rd_count = 0; su_cnt = 0; pw_cnt = 0; hd_cnt = 0;
    fall_cnt = 0; seen_fall = 0;
  endtask

  // issue a request and return clocks from acceptance to ack
  task automatic run_op(input logic [1:0] op, input logic [18:0] a,
                        input logic [7:0] d, output int lat);
    @(negedge clk);
    req = 1'b1; req_op = op; req_addr = a; req_wdata = d;
    @(negedge clk);
    req = 1'b0;
    lat = 0;
    while (!ack && lat < 2000) begin
      @(negedge clk);
      lat++;
    end
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk(fl_ce_n && fl_oe_n && fl_we_n, "R1 strobes idle", {fl_ce_n, fl_oe_n, fl_we_n}, 7);
    chk(!fl_dq_oe && !ack && !err && !busy, "R1 flags low",
        {fl_dq_oe, ack, err, busy}, 0);
  endtask

  task automatic t_read(input logic [18:0] a);
    int lat;
    logic [7:0] exp;
    exp = mem[a[5:0]];
    clear_mon();
    run_op(2'b00, a, 8'h00, lat);
    chk(rdata == exp, "R2 read data", rdata, exp);
    chk(rd_len == E_ACC, "R2 strobe window", rd_len, E_ACC);
    chk(lat == E_RC, "R3 read ack latency", lat, E_RC);
    @(negedge clk);
    chk(!ack, "R7 ack single clock", ack, 0);
  endtask

  task automatic t_write(input logic [18:0] a, input logic [7:0] d);
    int lat;
    clear_mon();
    run_op(2'b01, a, d, lat);
    chk(lat == E_SU + E_PW + E_HD, "R4 write ack latency", lat, E_SU + E_PW + E_HD);
    chk(su_cnt == E_SU, "R4 setup clocks", su_cnt, E_SU);
    chk(pw_cnt == E_PW, "R4 pulse clocks", pw_cnt, E_PW);
    chk(hd_cnt == E_HD, "R4 hold clocks", hd_cnt, E_HD);
    chk(mem[a[5:0]] == d, "R4 written byte", mem[a[5:0]], d);
    chk(wr_addr_seen == a, "R10 write address", int'(wr_addr_seen), int'(a));
    @(negedge clk);
    chk(!ack, "R7 ack single clock", ack, 0);
  endtask

  task automatic t_ignore_busy();
    int lat;
    clear_mon();
    @(negedge clk);
    req = 1'b1; req_op = 2'b00; req_addr = 19'h00011;
    @(negedge clk);
    req = 1'b0;
    @(negedge clk);
    req = 1'b1; req_op = 2'b01; req_addr = 19'h00022; req_wdata = 8'h5A;
    @(negedge clk);
    req = 1'b0;
    lat = 0;
    while (!ack && lat < 100) begin @(negedge clk); lat++; end
    repeat (8) @(negedge clk);
    chk(fall_cnt == 0, "R6 busy request dropped", fall_cnt, 0);
    chk(!busy && fl_ce_n, "R6 stays idle", busy, 0);
  endtask

  task automatic t_poll_done(input int flips);
    int lat;
    int nreads;
    logic [7:0] exp;
    nreads = flips + 2;
    clear_mon();
    poll_mode = 1; tog = 0; tog_left = flips; tog_forever = 0;
    exp = stat_byte(flips % 2 == 1);
    run_op(2'b10, 19'h70000, 8'h00, lat);
    chk(!err, "R8 no error on match", err, 0);
    chk(lat == nreads * E_RC, "R8 poll latency", lat, nreads * E_RC);
    chk(rdata == exp, "R8 last status byte", rdata, exp);
    chk(fl_addr == 19'h70000, "R8 poll address", int'(fl_addr), 32'h70000);
    @(negedge clk);
    poll_mode = 0;
  endtask

  task automatic t_poll_timeout(input logic [1:0] op, input int limit);
    int lat;
    int n;
    n = 1;
    while (n * E_RC <= limit) n++;
    clear_mon();
    poll_mode = 1; tog = 0; tog_forever = 1;
    run_op(op, 19'h10000, 8'h00, lat);
    chk(err == 1'b1, "R9 timeout error", err, 1);
    chk(lat == n * E_RC, "R9 timeout latency", lat, n * E_RC);
    @(negedge clk);
    chk(!err && !ack, "R7 err/ack single clock", {err, ack}, 0);
    poll_mode = 0; tog_forever = 0;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 8'(i * 3 + 1);
    repeat (4) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_read(19'h00005);
    t_read(19'h7FFFF);
    t_write(19'h00009, 8'hC3);
    t_read(19'h00009);
    t_write(19'h4003E, 8'h00);
    t_write(19'h4003E, 8'hFF);
    t_read(19'h0003E);
    t_ignore_busy();
    t_poll_done(3);
    t_poll_done(0);
    t_poll_timeout(2'b10, P_PGM);
    t_poll_timeout(2'b11, P_ERS);
    chk(excl_bad == 0, "R5 strobe exclusion", excl_bad, 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL R7 watchdog actual=%0d expected=%0d", cyc, 50000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule